// File: doc/BRIEF.md
# NOR Flash Block Erase Sequencer

This block runs a single block erase on a parallel NOR flash device that speaks the extended command set. A one-cycle start request carries the block address. The sequencer first turns on programming power. It then drives the two-step erase command onto the flash bus and polls the device status until the device reports ready or a millisecond timeout runs out.

After polling ends, the sequencer clears the device status and puts the device back into read-array mode. It reports the outcome in two forms: separate error flags, and a single prioritised error code. The surrounding system picks the block to erase and interprets the result.

The flash bus is a simple strobed interface. A write is one cycle with `flWe` high, the address and the data. A read is one cycle with `flRe` high, and the device returns `flRdData` on the following cycle.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, all of the following are low: `busy`, `done`, `progPowerEn`, `flWe`, `flRe`, every error flag and `errCode`.
- R2: A start request seen while idle is accepted. In the next cycle `busy` and `progPowerEn` are both high, and this is before any bus write.
- R3: Each operation makes exactly four bus writes, all to the latched block address, in this order: 0x20, 0xD0, 0x50, 0xFF.
- R4: After the 0xD0 write, the block address is read on every second cycle. Polling stops at the first read whose bit 7 (ready) is set, so a device that becomes ready on read k+1 sees exactly k+1 reads.
- R5: If ready never appears, polling stops at the first evaluation where at least TIMEOUT_MS × CYCLES_PER_MS counted polling cycles have elapsed, and `timeoutErr` is set. A ready seen in that same evaluation wins over the timeout.
- R6: `progPowerEn` is high at both erase command writes and at every status read. It is low at the 0x50 write, at the 0xFF write and at `done`.
- R7: Each flag is taken from the final status read and held until the next accepted start: `lockErr` from bit 1, `voltErr` from bit 3, `progErr` from bit 4 and `eraseErr` from bit 5. Bits 0, 2 and 6 have no effect on any flag.
- R8: `errCode` is 4 on timeout. Otherwise it is 1 if the lock bit is set, else 2 if the voltage bit is set, else 3 if the program or erase bit is set, else 0.
- R9: `done` is a one-cycle pulse. `busy` stays high from the cycle after an accepted start through the `done` cycle and is low in the cycle after it.
- R10: A start request raised while `busy` is high has no effect: the address, the command sequence and the number of `done` pulses are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request to erase the block at `blockAddr` |
| blockAddr | input | ADDR_W | Address of the block to erase |
| flAddr | output | ADDR_W | Flash bus address |
| flWrData | output | DATA_W | Flash bus write data (command byte) |
| flWe | output | 1 | Flash bus write strobe |
| flRe | output | 1 | Flash bus read strobe |
| flRdData | input | DATA_W | Flash read data, valid the cycle after `flRe` |
| progPowerEn | output | 1 | Programming power enable |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| lockErr | output | 1 | Block locked |
| voltErr | output | 1 | Programming voltage low |
| progErr | output | 1 | Program failure bit |
| eraseErr | output | 1 | Erase failure bit |
| timeoutErr | output | 1 | Ready never seen before timeout |
| errCode | output | 3 | Prioritised error code |

## Verification
Every one of the sixteen combinations of the four error bits is applied, with noise in the unused status bits for half of them. Each combination runs with the device becoming ready on the first, second and fourth read. This separates the flag decode from the priority encoding, and shows that the read count tracks the device rather than a fixed wait.

A device that never becomes ready is used to expose the timeout bound and its interaction with the error code. A start request raised in the middle of polling, with a different address, shows whether a running operation can be disturbed.

// File: rtl/fes_pkg.sv
package fes_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PWRUP,
    ST_SETUP,
    ST_CONFIRM,
    ST_POLLREQ,
    ST_POLLEVAL,
    ST_CLEAR,
    ST_READMODE,
    ST_FINISH
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;
    logic timerClear;
    logic timerRun;
    logic finish;
  } dpStrobe_t;

  localparam logic [7:0] CMD_ERASE_SETUP   = 8'h20;
  localparam logic [7:0] CMD_ERASE_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_CLEAR_STATUS  = 8'h50;
  localparam logic [7:0] CMD_READ_ARRAY    = 8'hFF;

  localparam int READY_BIT = 7;
  localparam int LOCK_BIT  = 1;
  localparam int VOLT_BIT  = 3;
  localparam int PROG_BIT  = 4;
  localparam int ERASE_BIT = 5;

  localparam logic [2:0] ERR_NONE    = 3'd0;
  localparam logic [2:0] ERR_LOCK    = 3'd1;
  localparam logic [2:0] ERR_VOLT    = 3'd2;
  localparam logic [2:0] ERR_IO      = 3'd3;
  localparam logic [2:0] ERR_TIMEOUT = 3'd4;

endpackage

// File: rtl/fes_ctrl.sv
module fes_ctrl
  import fes_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              statusReady,
  input  logic              timedOut,
  output dpStrobe_t         strobe,
  output logic              busy,
  output logic              done,
  output logic              progPowerEn,
  output logic              flWe,
  output logic              flRe,
  output logic [DATA_W-1:0] flWrData
);

  seqState_t state, nextState;
  logic [7:0] cmdByte;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:     if (startReq) nextState = ST_PWRUP;
      ST_PWRUP:    nextState = ST_SETUP;
      ST_SETUP:    nextState = ST_CONFIRM;
      ST_CONFIRM:  nextState = ST_POLLREQ;
      ST_POLLREQ:  nextState = ST_POLLEVAL;
      ST_POLLEVAL: nextState = (statusReady || timedOut) ? ST_CLEAR : ST_POLLREQ;
      ST_CLEAR:    nextState = ST_READMODE;
      ST_READMODE: nextState = ST_FINISH;
      ST_FINISH:   nextState = ST_IDLE;
      default:     nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state)
      ST_SETUP:    cmdByte = CMD_ERASE_SETUP;
      ST_CONFIRM:  cmdByte = CMD_ERASE_CONFIRM;
      ST_CLEAR:    cmdByte = CMD_CLEAR_STATUS;
      ST_READMODE: cmdByte = CMD_READ_ARRAY;
      default:     cmdByte = 8'h00;
    endcase
  end

  assign flWrData    = DATA_W'(cmdByte);
  assign flWe        = (state == ST_SETUP) || (state == ST_CONFIRM) ||
                       (state == ST_CLEAR) || (state == ST_READMODE);
  assign flRe        = (state == ST_POLLREQ);
  assign busy        = (state != ST_IDLE);
  assign done        = (state == ST_FINISH);
  assign progPowerEn = (state == ST_PWRUP)   || (state == ST_SETUP) ||
                       (state == ST_CONFIRM) || (state == ST_POLLREQ) ||
                       (state == ST_POLLEVAL);

  assign strobe.accept     = (state == ST_IDLE) && startReq;
  assign strobe.timerClear = (state == ST_CONFIRM);
  assign strobe.timerRun   = (state == ST_POLLREQ) || (state == ST_POLLEVAL);
  assign strobe.finish     = (state == ST_POLLEVAL) && (statusReady || timedOut);

endmodule

// File: rtl/fes_dp.sv
module fes_dp
  import fes_pkg::*;
#(
  parameter int ADDR_W        = 24,
  parameter int DATA_W        = 8,
  parameter int CYCLES_PER_MS = 100000,
  parameter int TIMEOUT_MS    = 1500
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] blockAddr,
  input  logic [DATA_W-1:0] flRdData,
  output logic [ADDR_W-1:0] flAddr,
  output logic              statusReady,
  output logic              timedOut,
  output logic              lockErr,
  output logic              voltErr,
  output logic              progErr,
  output logic              eraseErr,
  output logic              timeoutErr,
  output logic [2:0]        errCode
);

  localparam int PRE_W = $clog2(CYCLES_PER_MS + 1);
  localparam int MS_W  = $clog2(TIMEOUT_MS + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYCLES_PER_MS - 1);
  localparam logic [MS_W-1:0]  MS_LIMIT = MS_W'(TIMEOUT_MS);

  logic [PRE_W-1:0] preCount;
  logic [MS_W-1:0]  msCount;
  logic [2:0]       codeNext;

  always_ff @(posedge clk) begin
    if (!rstN)               flAddr <= '0;
    else if (strobe.accept)  flAddr <= blockAddr;
  end

  // prescaled millisecond counter, saturates at the limit
  always_ff @(posedge clk) begin
    if (!rstN || strobe.timerClear) begin
      preCount <= '0;
      msCount  <= '0;
    end else if (strobe.timerRun && !timedOut) begin
      if (preCount == PRE_LAST) begin
        preCount <= '0;
        msCount  <= msCount + 1'b1;
      end else begin
        preCount <= preCount + 1'b1;
      end
    end
  end

  assign timedOut    = (msCount >= MS_LIMIT);
  assign statusReady = flRdData[READY_BIT];

  always_comb begin
    if (!statusReady)                               codeNext = ERR_TIMEOUT;
    else if (flRdData[LOCK_BIT])                    codeNext = ERR_LOCK;
    else if (flRdData[VOLT_BIT])                    codeNext = ERR_VOLT;
    else if (flRdData[PROG_BIT] || flRdData[ERASE_BIT]) codeNext = ERR_IO;
    else                                            codeNext = ERR_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.accept) begin
      lockErr    <= 1'b0;
      voltErr    <= 1'b0;
      progErr    <= 1'b0;
      eraseErr   <= 1'b0;
      timeoutErr <= 1'b0;
      errCode    <= ERR_NONE;
    end else if (strobe.finish) begin
      lockErr    <= flRdData[LOCK_BIT];
      voltErr    <= flRdData[VOLT_BIT];
      progErr    <= flRdData[PROG_BIT];
      eraseErr   <= flRdData[ERASE_BIT];
      timeoutErr <= !statusReady;
      errCode    <= codeNext;
    end
  end

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import fes_pkg::*;
#(
  parameter int ADDR_W        = 24,
  parameter int DATA_W        = 8,
  parameter int CYCLES_PER_MS = 100000,
  parameter int TIMEOUT_MS    = 1500
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [ADDR_W-1:0] blockAddr,
  output logic [ADDR_W-1:0] flAddr,
  output logic [DATA_W-1:0] flWrData,
  output logic              flWe,
  output logic              flRe,
  input  logic [DATA_W-1:0] flRdData,
  output logic              progPowerEn,
  output logic              busy,
  output logic              done,
  output logic              lockErr,
  output logic              voltErr,
  output logic              progErr,
  output logic              eraseErr,
  output logic              timeoutErr,
  output logic [2:0]        errCode
);

  dpStrobe_t strobe;
  logic      statusReady;
  logic      timedOut;

  fes_ctrl #(.DATA_W(DATA_W)) ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .statusReady(statusReady), .timedOut(timedOut), .strobe(strobe),
    .busy(busy), .done(done), .progPowerEn(progPowerEn),
    .flWe(flWe), .flRe(flRe), .flWrData(flWrData)
  );

  fes_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CYCLES_PER_MS(CYCLES_PER_MS), .TIMEOUT_MS(TIMEOUT_MS)
  ) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .blockAddr(blockAddr),
    .flRdData(flRdData), .flAddr(flAddr), .statusReady(statusReady),
    .timedOut(timedOut), .lockErr(lockErr), .voltErr(voltErr),
    .progErr(progErr), .eraseErr(eraseErr), .timeoutErr(timeoutErr),
    .errCode(errCode)
  );

endmodule

// File: rtl/fes_checker.sv
module fes_checker #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              startReq,
  input logic              busy,
  input logic              done,
  input logic              flWe,
  input logic              flRe,
  input logic              progPowerEn,
  input logic              lockErr,
  input logic [2:0]        errCode,
  input logic [ADDR_W-1:0] flAddr
);

  // R9
  done_has_busy_chk: assert property (@(posedge clk) disable iff (!rstN) done |-> busy);
  // R9
  done_then_idle_chk: assert property (@(posedge clk) disable iff (!rstN) done |=> !busy);
  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN) busy && !done |=> busy);
  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    startReq && !busy |=> busy && progPowerEn);
  // R6
  read_powered_chk: assert property (@(posedge clk) disable iff (!rstN) flRe |-> progPowerEn);
  // R6
  done_unpowered_chk: assert property (@(posedge clk) disable iff (!rstN) done |-> !progPowerEn);
  // R3
  bus_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN) !(flWe && flRe));
  // R8
  lock_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    done && errCode == 3'd1 |-> lockErr);
  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && !done |=> $stable(flAddr));

endmodule

bind flash_erase_seq fes_checker #(.ADDR_W(ADDR_W)) chk (
  .clk(clk), .rstN(rstN), .startReq(startReq), .busy(busy), .done(done),
  .flWe(flWe), .flRe(flRe), .progPowerEn(progPowerEn), .lockErr(lockErr),
  .errCode(errCode), .flAddr(flAddr)
);

// File: tb/flash_erase_seq_test.sv
module flash_erase_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW  = 16;
  localparam int DW  = 8;
  localparam int CPM = 4;
  localparam int TMS = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startReq = 1'b0;
  logic [AW-1:0] blockAddr = '0;
  logic [AW-1:0] flAddr;
  logic [DW-1:0] flWrData;
  logic          flWe, flRe;
  logic [DW-1:0] flRdData;
  logic          progPowerEn, busy, done;
  logic          lockErr, voltErr, progErr, eraseErr, timeoutErr;
  logic [2:0]    errCode;

  int vectors = 0;
  int misses  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_erase_seq #(.ADDR_W(AW), .DATA_W(DW), .CYCLES_PER_MS(CPM), .TIMEOUT_MS(TMS)) uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .blockAddr(blockAddr),
    .flAddr(flAddr), .flWrData(flWrData), .flWe(flWe), .flRe(flRe),
    .flRdData(flRdData), .progPowerEn(progPowerEn), .busy(busy), .done(done),
    .lockErr(lockErr), .voltErr(voltErr), .progErr(progErr), .eraseErr(eraseErr),
    .timeoutErr(timeoutErr), .errCode(errCode)
  );

  // flash device model
  logic          modelClear = 1'b0;
  logic [AW-1:0] opAddr = '0;
  logic [7:0]    errBits = '0;
  int            readyAfter = 0;
  int            wrCount, rdCount, rdBadAddr, rdNoPwr, doneCount;
  logic [AW-1:0] wrAddr [0:7];
  logic [7:0]    wrData [0:7];
  logic          wrPwr  [0:7];

  always @(posedge clk) begin
    if (modelClear) begin
      wrCount = 0; rdCount = 0; rdBadAddr = 0; rdNoPwr = 0; doneCount = 0;
      flRdData <= '0;
    end else begin
      if (flWe && wrCount < 8) begin
        wrAddr[wrCount] = flAddr;
        wrData[wrCount] = flWrData;
        wrPwr[wrCount]  = progPowerEn;
        wrCount = wrCount + 1;
      end else if (flWe) wrCount = wrCount + 1;
      if (flRe) begin
        if (flAddr != opAddr) rdBadAddr = rdBadAddr + 1;
        if (!progPowerEn) rdNoPwr = rdNoPwr + 1;
        flRdData <= (rdCount >= readyAfter) ? (errBits | 8'h80) : (errBits & 8'h7F);
        rdCount = rdCount + 1;
      end
      if (done) doneCount = doneCount + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expCode(input logic [7:0] e, input bit tmo);
    if (tmo)                 return 4;
    if (e[1])                return 1;
    if (e[3])                return 2;
    if (e[4] || e[5])        return 3;
    return 0;
  endfunction

  task automatic runErase(input logic [AW-1:0] addr, input logic [7:0] e,
                          input int ra, input bit tmo, input bit poke);
    int cyc;
    logic [7:0] cmds [0:3];
    cmds[0] = 8'h20; cmds[1] = 8'hD0; cmds[2] = 8'h50; cmds[3] = 8'hFF;
    @(negedge clk) modelClear = 1'b1;
    @(negedge clk) modelClear = 1'b0;
    errBits = e; readyAfter = ra; opAddr = addr;
    blockAddr = addr; startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    // R2: busy and power one cycle after start, no write yet
    check(busy && progPowerEn && wrCount == 0, "R2 busy/power after start", int'({busy, progPowerEn}), 3);
    cyc = 0;
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 4) begin startReq = 1'b1; blockAddr = ~addr; end
      if (poke && cyc == 5) startReq = 1'b0;
      if (poke && cyc == 5) begin startReq = 1'b0; blockAddr = addr; end
    end
    check(done == 1'b1, "R9 done pulse seen", int'(done), 1);
    check(!progPowerEn, "R6 power off at done", int'(progPowerEn), 0);
    // R7 flags from final status
    check({lockErr, voltErr, progErr, eraseErr} == {e[1], e[3], e[4], e[5]},
          "R7 error flags", int'({lockErr, voltErr, progErr, eraseErr}),
          int'({e[1], e[3], e[4], e[5]}));
    check(timeoutErr == tmo, "R5 timeout flag", int'(timeoutErr), int'(tmo));
    check(int'(errCode) == expCode(e, tmo), "R8 error code", int'(errCode), expCode(e, tmo));
    // R4 / R5 read counts
    if (tmo)
      check(rdCount == (CPM*TMS + 2)/2, "R5 reads before timeout", rdCount, (CPM*TMS + 2)/2);
    else
      check(rdCount == ra + 1, "R4 poll read count", rdCount, ra + 1);
    check(rdBadAddr == 0, "R4 poll address", rdBadAddr, 0);
    check(rdNoPwr == 0, "R6 power during reads", rdNoPwr, 0);
    // R3 command sequence
    check(wrCount == 4, "R3 write count", wrCount, 4);
    for (int i = 0; i < 4; i++) begin
      check(wrData[i] == cmds[i], "R3 command byte", int'(wrData[i]), int'(cmds[i]));
      check(wrAddr[i] == addr, "R3 command address", int'(wrAddr[i]), int'(addr));
      check(wrPwr[i] == (i < 2), "R6 power at command", int'(wrPwr[i]), int'(i < 2));
    end
    @(negedge clk);
    check(!busy && !done, "R9 idle after done", int'({busy, done}), 0);
    check(doneCount == 1, poke ? "R10 single done despite start" : "R9 single done", doneCount, 1);
    // R7 flags held while idle
    check(int'(errCode) == expCode(e, tmo), "R7 code held", int'(errCode), expCode(e, tmo));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    misses++;
    $display("FAIL watchdog R9 actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({busy, done, progPowerEn, flWe, flRe} == 5'b0, "R1 control outputs",
          int'({busy, done, progPowerEn, flWe, flRe}), 0);
    check({lockErr, voltErr, progErr, eraseErr, timeoutErr} == 5'b0 && errCode == 3'd0,
          "R1 error outputs", int'(errCode), 0);
    // sweep over error-bit combinations and ready latencies
    for (int c = 0; c < 16; c++) begin
      for (int r = 0; r < 3; r++) begin
        logic [7:0] e;
        int ra;
        e = {2'b00, c[3], c[2], c[1], 1'b0, c[0], 1'b0};
        if (c[0]) e = e | 8'h45;  // noise in bits 0, 2, 6
        ra = (r == 0) ? 0 : ((r == 1) ? 1 : 3);
        runErase(AW'(16'h1000 + c * 16'h0100 + r), e, ra, 1'b0, 1'b0);
      end
    end
    // R5 timeout, plain and with lock bit set
    runErase(16'hA000, 8'h00, 1000, 1'b1, 1'b0);
    runErase(16'hB000, 8'h02, 1000, 1'b1, 1'b0);
    // R10 start raised during polling
    runErase(16'h5A5A, 8'h10, 4, 1'b0, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule